// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block provides doorbell signalling between the two sides of a shared dual-port memory of 2^ADDR_W words. Each side has a chip select, a write strobe, an output enable and an address, all active low except the address. The block samples both sides on one clock and drives one active-low interrupt flag per side. The flags are never touched by the memory contents.

The two highest addresses are reserved as mailboxes. The topmost word carries messages for the right side. A left-side write to it raises the right flag. A right-side read of it lowers that flag again. The word just below carries messages for the left side. A right-side write to it raises the left flag, and a left-side read of it clears that flag. When a raise and a clear for the same flag land in one sampled cycle, the raise wins, so a message can never be lost.

All decisions are taken at a rising clock edge. A flag output changes at the edge that samples the causing access.

Top module: `mbx_irq_logic`

## Requirements
- R1: While `rst` is high at a clock edge, both `l_irq_n` and `r_irq_n` are driven high (inactive) after that edge.
- R2: A left write to address 2^ADDR_W-1 (0x7FF by default) drives `r_irq_n` low after the sampling edge. A write is `l_sel_n`=0 together with `l_wr_n`=0.
- R3: A right read of address 2^ADDR_W-1 drives `r_irq_n` high after the sampling edge. A read is `r_sel_n`=0, `r_wr_n`=1 and `r_oe_n`=0.
- R4: A right write (`r_sel_n`=0, `r_wr_n`=0) to address 2^ADDR_W-2 (0x7FE by default) drives `l_irq_n` low after the sampling edge.
- R5: A left read (`l_sel_n`=0, `l_wr_n`=1, `l_oe_n`=0) of address 2^ADDR_W-2 drives `l_irq_n` high after the sampling edge.
- R6: A write strobe while the side's chip select is high raises no flag. A chip select without the write strobe also raises no flag.
- R7: The following accesses clear no flag: a mailbox access with the output enable high, with the chip select high, or with the write strobe low.
- R8: When a raise and a clear for the same flag are sampled in the same cycle, the flag is low after that edge.
- R9: Accesses to non-mailbox addresses leave both flags unchanged. So does a side's write to the mailbox it reads from, and a side's read of the mailbox it writes to.
- R10: With no raising and no clearing access, both flags hold their value from edge to edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel_n | input | 1 | Left chip select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| r_sel_n | input | 1 | Right chip select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| l_irq_n | output | 1 | Left interrupt flag, active low |
| r_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
Every flag result is due one edge after its stimulus. An access presented before rising edge N is reflected on the flags just after edge N, with no further delay. The bench changes inputs on falling edges and reads the flags at the next falling edge. That point is half a period after the edge that owns the result and before the next stimulus can act. Cases with no effect are checked in the same slot, by reading that both flags keep the value the bench's own model predicts.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

    // Decoded, active-high view of one side's strobes
    typedef struct packed {
        logic sel;
        logic wr;
        logic oe;
    } bus_ctl_t;

    // Per-side mailbox events
    typedef struct packed {
        logic post;   // wrote the peer's mailbox
        logic take;   // read own mailbox
    } mbx_hit_t;

    function automatic bus_ctl_t to_ctl(input logic sel_n, input logic wr_n, input logic oe_n);
        bus_ctl_t c;
        c.sel = ~sel_n;
        c.wr  = ~wr_n;
        c.oe  = ~oe_n;
        return c;
    endfunction

    function automatic side_e peer_of(input side_e s);
        return (s == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] TX_ADDR = '1,
    parameter logic [ADDR_W-1:0] RX_ADDR = '0
) (
    input  bus_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr,
    output mbx_hit_t          hit
);
    logic is_write;
    logic is_read;

    always_comb begin
        is_write = ctl.sel & ctl.wr;
        is_read  = ctl.sel & ~ctl.wr & ctl.oe;
        hit.post = is_write & (addr == TX_ADDR);
        hit.take = is_read  & (addr == RX_ADDR);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic lower,
    output logic flag_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (raise)
            pending <= 1'b1;      // raise has priority over lower
        else if (lower)
            pending <= 1'b0;
    end

    assign flag_n = ~pending;
endmodule

// File: rtl/mbx_irq_logic.sv
module mbx_irq_logic
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    // Topmost word: right side's inbox; word below: left side's inbox
    localparam logic [ADDR_W-1:0] BOX_R = '1;
    localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

    bus_ctl_t          ctl   [NUM_SIDES];
    logic [ADDR_W-1:0] addr  [NUM_SIDES];
    mbx_hit_t          hit   [NUM_SIDES];
    logic              irq_n [NUM_SIDES];

    assign ctl[SIDE_L]  = to_ctl(l_sel_n, l_wr_n, l_oe_n);
    assign ctl[SIDE_R]  = to_ctl(r_sel_n, r_wr_n, r_oe_n);
    assign addr[SIDE_L] = l_addr;
    assign addr[SIDE_R] = r_addr;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN_BOX  = (s == int'(SIDE_L)) ? BOX_L : BOX_R;
        localparam logic [ADDR_W-1:0] PEER_BOX = (s == int'(SIDE_L)) ? BOX_R : BOX_L;

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .TX_ADDR (PEER_BOX),
            .RX_ADDR (OWN_BOX)
        ) u_dec (
            .ctl  (ctl[s]),
            .addr (addr[s]),
            .hit  (hit[s])
        );

        // This side's flag: raised by the peer's post, lowered by own take
        mbx_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .raise  (hit[1-s].post),
            .lower  (hit[s].take),
            .flag_n (irq_n[s])
        );
    end

    assign l_irq_n = irq_n[SIDE_L];
    assign r_irq_n = irq_n[SIDE_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              l_sel_n,
    input logic              l_wr_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_sel_n,
    input logic              r_wr_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] HI = '1;
    localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

    logic l_post, r_post, l_take, r_take;
    assign l_post = !l_sel_n && !l_wr_n && (l_addr == HI);
    assign r_post = !r_sel_n && !r_wr_n && (r_addr == LO);
    assign l_take = !l_sel_n && l_wr_n && !l_oe_n && (l_addr == LO);
    assign r_take = !r_sel_n && r_wr_n && !r_oe_n && (r_addr == HI);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n));

    assert_left_post_R2: assert property (@(posedge clk) disable iff (rst)
        l_post |=> !r_irq_n);

    assert_right_take_R3: assert property (@(posedge clk) disable iff (rst)
        (r_take && !l_post) |=> r_irq_n);

    assert_right_post_R4: assert property (@(posedge clk) disable iff (rst)
        r_post |=> !l_irq_n);

    assert_left_take_R5: assert property (@(posedge clk) disable iff (rst)
        (l_take && !r_post) |=> l_irq_n);

    assert_hold_right_R10: assert property (@(posedge clk) disable iff (rst)
        (!l_post && !r_take) |=> $stable(r_irq_n));

    assert_hold_left_R10: assert property (@(posedge clk) disable iff (rst)
        (!r_post && !l_take) |=> $stable(l_irq_n));
endmodule

bind mbx_irq_logic mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbx_irq_logic_test.sv
module mbx_irq_logic_test;
    localparam int AW = 11;
    localparam int NV = 23;
    // Control codes {sel_n, wr_n, oe_n}
    localparam logic [2:0] IDL = 3'b111, WR = 3'b001, RD = 3'b010;

    // Entry: {l_ctl, l_addr, r_ctl, r_addr, exp_l_irq_n, exp_r_irq_n}
    localparam logic [29:0] VEC [NV] = '{
        {IDL, 11'h000, IDL, 11'h000, 2'b11},  //  0 R10 idle
        {WR,  11'h7FF, IDL, 11'h000, 2'b10},  //  1 R2
        {IDL, 11'h000, IDL, 11'h000, 2'b10},  //  2 R10
        {RD,  11'h7FF, IDL, 11'h000, 2'b10},  //  3 R9 left reads peer box
        {IDL, 11'h000, 3'b011, 11'h7FF, 2'b10}, // 4 R7 oe high
        {IDL, 11'h000, RD,  11'h7FF, 2'b11},  //  5 R3
        {IDL, 11'h000, WR,  11'h7FE, 2'b01},  //  6 R4
        {WR,  11'h7FE, IDL, 11'h000, 2'b01},  //  7 R9 left writes own box
        {3'b110, 11'h7FE, IDL, 11'h000, 2'b01}, // 8 R7 sel high
        {RD,  11'h7FE, IDL, 11'h000, 2'b11},  //  9 R5
        {3'b101, 11'h7FF, IDL, 11'h000, 2'b11}, // 10 R6 no select
        {3'b011, 11'h7FF, IDL, 11'h000, 2'b11}, // 11 R6 no strobe
        {WR,  11'h7FD, WR,  11'h000, 2'b11},  // 12 R9 other address
        {WR,  11'h7FF, RD,  11'h7FF, 2'b10},  // 13 R8
        {IDL, 11'h000, RD,  11'h7FF, 2'b11},  // 14 R3
        {RD,  11'h7FE, WR,  11'h7FE, 2'b01},  // 15 R8
        {RD,  11'h7FE, IDL, 11'h000, 2'b11},  // 16 R5
        {WR,  11'h7FF, WR,  11'h7FE, 2'b00},  // 17 R2 R4 together
        {IDL, 11'h000, IDL, 11'h000, 2'b00},  // 18 R10
        {RD,  11'h7FE, RD,  11'h7FF, 2'b11},  // 19 R3 R5 together
        {WR,  11'h7FF, IDL, 11'h000, 2'b10},  // 20 R2
        {IDL, 11'h000, 3'b000, 11'h7FF, 2'b10}, // 21 R7 strobe low
        {IDL, 11'h000, RD,  11'h7FF, 2'b11}   // 22 R3
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sel_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1;
    logic r_sel_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mbx_irq_logic #(.ADDR_W(AW)) uut (.*);

    function automatic string tag_of(input int i);
        case (i)
            1, 17, 20:      return "R2";
            5, 14, 19, 22:  return "R3";
            6:              return "R4";
            9, 16:          return "R5";
            10, 11:         return "R6";
            4, 8, 21:       return "R7";
            13, 15:         return "R8";
            3, 7, 12:       return "R9";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] exp);
        checks++;
        if ({l_irq_n, r_irq_n} !== exp) begin
            fails++;
            $display("FAIL %s: flags {l,r} actual %b expected %b", tag, {l_irq_n, r_irq_n}, exp);
        end
    endtask

    task automatic apply(input logic [29:0] v);
        {l_sel_n, l_wr_n, l_oe_n} = v[29:27];
        l_addr = v[26:16];
        {r_sel_n, r_wr_n, r_oe_n} = v[15:13];
        r_addr = v[12:2];
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", 2'b11);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check(tag_of(i), VEC[i][1:0]);
        end

        // R10: long idle keeps raised flags
        apply({IDL, 11'h000, IDL, 11'h000, 2'b11});
        @(negedge clk);
        apply({WR, 11'h7FF, WR, 11'h7FE, 2'b00});
        @(negedge clk);
        apply({IDL, 11'h000, IDL, 11'h000, 2'b00});
        repeat (20) @(negedge clk);
        check("R10", 2'b00);

        // R1: reset while both raised
        rst = 1'b1;
        @(negedge clk);
        check("R1", 2'b11);
        rst = 1'b0;

        // R1: reset beats a simultaneous post
        apply({WR, 11'h7FF, WR, 11'h7FE, 2'b00});
        rst = 1'b1;
        @(negedge clk);
        check("R1", 2'b11);
        rst = 1'b0;
        @(negedge clk);
        check("R2", 2'b00);
        apply({IDL, 11'h000, IDL, 11'h000, 2'b00});
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule